// File: doc/BRIEF.md
# Prioritized CPU Interrupt Controller

This block sits between a set of interrupt request lines and a processor core. It watches up to 31 request inputs, numbered 1 to 31, and decides each clock whether one of them should be presented to the core and, if so, which. Every line carries its own enable bit, a sensitivity type (level or edge), and a 4-bit priority. A single threshold value masks every line whose priority lies below it. Software can therefore get nested preemption by raising the threshold to one above the priority of the handler it is running.

Configuration uses a simple word-wide register port: a write strobe with an address and data, plus a read data bus that is decoded combinationally. The register map is as follows.

- Address 0 holds the enable mask, where bit n belongs to line n.
- Address 1 holds the type mask, where bit n = 1 makes line n edge-sensitive.
- Address 2 is a write-only clear strobe for latched edges, and it reads as zero.
- Address 3 holds the threshold, in 5 bits.
- Addresses 32 + n hold the priority of line n, in the low 4 bits.

The outputs are a registered request flag and a registered 5-bit cause code that gives the winning line number.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the request output is 0, the cause code is 0, and the enable, type and threshold registers (addresses 0, 1, 3) read as 0.
- R2: Line 0 never raises a request, and bit 0 of the enable register always reads 0, even after a write of 1 to it.
- R3: A line raises a request only while its enable bit (address 0, bit n) is 1.
- R4: A line whose priority field is 0 is never taken, whatever its enable and input state.
- R5: Among eligible lines the one with the numerically highest priority wins (15 is highest).
- R6: When eligible lines tie on priority, the lowest line number wins.
- R7: A level line (type bit 0) is pending exactly while its input is 1. When the input falls, the request disappears.
- R8: An edge line (type bit 1) latches pending on a rising edge of its input, and stays pending after the input falls until it is cleared.
- R9: Writing 1 to bit n of address 2 removes the latched pending state of edge line n. The same write has no effect on a level line. If a rising edge and a clear arrive in the same cycle, the edge wins.
- R10: A line is eligible only when its priority is greater than or equal to the threshold. A threshold of p+1 masks priority p, and a threshold of 16 masks every line.
- R11: A register write takes effect on arbitration from the next clock. The request output is registered, so it reflects a change one cycle after the register updates.
- R12: The cause code equals the number of the winning line, and it is 0 when no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Interrupt request inputs, bit n is line n (bit 0 unused) |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_req | output | 1 | Interrupt request to the core |
| irq_cause | output | 5 | Number of the winning line |

## Verification
The assertions assume the following about the inputs:

- `irq_in` is synchronous to `clk`.
- Register writes are single-cycle strobes with stable address and data around the edge.
- The threshold is written only through address 3.

With those assumptions, a raised request must always point at a line that was enabled, had a nonzero priority and met the threshold one cycle earlier. The directed stimulus changes inputs and register writes only at falling edges, so every change lands in a known cycle. Each edge pulse lasts a full cycle, so the rising-edge detector sees it.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int LINES    = 32;
  localparam int PRIO_W   = 4;
  localparam int THR_W    = PRIO_W + 1;
  localparam int CAUSE_W  = $clog2(LINES);
  localparam int ADDR_W   = CAUSE_W + 1;
  localparam int DATA_W   = 32;

  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_TYPE   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_THRESH = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_PRIO   = ADDR_W'(LINES);
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_ctrl_pkg::*;
#(
  parameter int NL = LINES,
  parameter int PW = PRIO_W,
  parameter int TW = THR_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  output logic [NL-1:0]        en_q,
  output logic [NL-1:0]        type_q,
  output logic [NL-1:0][PW-1:0] prio_q,
  output logic [TW-1:0]        thr_q,
  output logic [NL-1:0]        clr_pulse
);
  localparam int IW = $clog2(NL);
  localparam logic [NL-1:0] LINE_MASK = {{(NL-1){1'b1}}, 1'b0};

  logic            en_we, type_we, thr_we, prio_sel;
  logic [IW-1:0]   prio_idx;
  logic [NL-1:0]   en_d, type_d;
  logic [TW-1:0]   thr_d;

  always_comb begin
    en_we    = we && (addr == A_ENABLE);
    type_we  = we && (addr == A_TYPE);
    thr_we   = we && (addr == A_THRESH);
    prio_sel = (addr >= A_PRIO);
    prio_idx = addr[IW-1:0];
    en_d     = wdata[NL-1:0] & LINE_MASK;
    type_d   = wdata[NL-1:0] & LINE_MASK;
    thr_d    = wdata[TW-1:0];
    clr_pulse = (we && (addr == A_CLEAR)) ? (wdata[NL-1:0] & LINE_MASK) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      type_q <= '0;
      thr_q  <= '0;
    end else begin
      if (en_we)   en_q   <= en_d;
      if (type_we) type_q <= type_d;
      if (thr_we)  thr_q  <= thr_d;
    end
  end

  assign prio_q[0] = '0;
  for (genvar n = 1; n < NL; n++) begin : g_prio
    logic pw_en;
    assign pw_en = we && prio_sel && (prio_idx == IW'(n));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     prio_q[n] <= '0;
      else if (pw_en) prio_q[n] <= wdata[PW-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (prio_sel)                rdata[PW-1:0] = prio_q[prio_idx];
    else if (addr == A_ENABLE)   rdata[NL-1:0] = en_q;
    else if (addr == A_TYPE)     rdata[NL-1:0] = type_q;
    else if (addr == A_THRESH)   rdata[TW-1:0] = thr_q;
  end

  // R2: bit 0 of the enable register stays clear whatever was written
  a_r2_no_line0_enable: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> !en_q[0]);
endmodule

// File: rtl/irq_line_pending.sv
module irq_line_pending
  import irq_ctrl_pkg::*;
#(
  parameter int NL = LINES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] irq_in,
  input  logic [NL-1:0] type_q,
  input  logic [NL-1:0] clr_pulse,
  output logic [NL-1:0] pend
);
  assign pend[0] = 1'b0;

  for (genvar n = 1; n < NL; n++) begin : g_line
    logic prev_q, latch_q, latch_d, rise;

    always_comb begin
      rise    = irq_in[n] && !prev_q;
      latch_d = type_q[n] ? ((latch_q && !clr_pulse[n]) || rise) : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q  <= 1'b0;
        latch_q <= 1'b0;
      end else begin
        prev_q  <= irq_in[n];
        latch_q <= latch_d;
      end
    end

    assign pend[n] = type_q[n] ? latch_q : irq_in[n];

    // R8: a latched edge stays set while no clear is written
    a_r8_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q && type_q[n] && !clr_pulse[n]) |=> latch_q);
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctrl_pkg::*;
#(
  parameter int NL = LINES,
  parameter int PW = PRIO_W,
  parameter int TW = THR_W,
  parameter int CW = CAUSE_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NL-1:0]         en_q,
  input  logic [NL-1:0]         pend,
  input  logic [NL-1:0][PW-1:0] prio_q,
  input  logic [TW-1:0]         thr_q,
  output logic                  irq_req,
  output logic [CW-1:0]         irq_cause
);
  logic [NL-1:0] elig;
  logic          best_v;
  logic [CW-1:0] best_i;
  logic [PW-1:0] best_p;
  logic          req_d;
  logic [CW-1:0] cause_d;

  assign elig[0] = 1'b0;
  for (genvar n = 1; n < NL; n++) begin : g_elig
    assign elig[n] = en_q[n] && pend[n] && (prio_q[n] != '0)
                     && ({1'b0, prio_q[n]} >= thr_q);
  end

  always_comb begin
    best_v = 1'b0;
    best_i = '0;
    best_p = '0;
    for (int i = 1; i < NL; i++) begin
      if (elig[i] && (!best_v || (prio_q[i] > best_p))) begin
        best_v = 1'b1;
        best_i = CW'(i);
        best_p = prio_q[i];
      end
    end
    req_d   = best_v;
    cause_d = best_v ? best_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req   <= 1'b0;
      irq_cause <= '0;
    end else begin
      irq_req   <= req_d;
      irq_cause <= cause_d;
    end
  end

  // R2: a raised request never names line 0
  a_r2_cause_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_cause != '0));
  // R12: the cause code is zero whenever no request is raised
  a_r12_idle_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_cause == '0));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES-1:0]   irq_in,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_req,
  output logic [CAUSE_W-1:0] irq_cause
);
  logic [LINES-1:0]             en_q, type_q, clr_pulse, pend;
  logic [LINES-1:0][PRIO_W-1:0] prio_q;
  logic [THR_W-1:0]             thr_q;

  irq_cfg_regs i_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .en_q(en_q), .type_q(type_q), .prio_q(prio_q),
    .thr_q(thr_q), .clr_pulse(clr_pulse)
  );

  irq_line_pending i_pend (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .type_q(type_q),
    .clr_pulse(clr_pulse), .pend(pend)
  );

  irq_arbiter i_arb (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .pend(pend), .prio_q(prio_q),
    .thr_q(thr_q), .irq_req(irq_req), .irq_cause(irq_cause)
  );

  // Delayed view of the configuration that fed the registered outputs
  logic [LINES-1:0]             en_d1;
  logic [LINES-1:0][PRIO_W-1:0] prio_d1;
  logic [THR_W-1:0]             thr_d1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_d1   <= '0;
      prio_d1 <= '0;
      thr_d1  <= '0;
    end else begin
      en_d1   <= en_q;
      prio_d1 <= prio_q;
      thr_d1  <= thr_q;
    end
  end

  // R3: the reported line was enabled
  a_r3_winner_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> en_d1[irq_cause]);
  // R4: the reported line had a nonzero priority
  a_r4_winner_prio: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (prio_d1[irq_cause] != '0));
  // R10: the reported line met the threshold
  a_r10_winner_thresh: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ({1'b0, prio_d1[irq_cause]} >= thr_d1));
endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
  import irq_ctrl_pkg::*;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [LINES-1:0]   irq_in;
  logic               reg_we;
  logic [ADDR_W-1:0]  reg_addr;
  logic [DATA_W-1:0]  reg_wdata;
  logic [DATA_W-1:0]  reg_rdata;
  logic               irq_req;
  logic [CAUSE_W-1:0] irq_cause;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_cause(irq_cause)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic chk_out(string tag, logic r, int c);
    chk({tag, " req"}, 32'(irq_req), 32'(r));
    chk({tag, " cause"}, 32'(irq_cause), 32'(c));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk_out("R1 reset", 1'b0, 0);
    rd(A_ENABLE, d); chk("R1 enable reset", d, 0);
    rd(A_TYPE, d);   chk("R1 type reset", d, 0);
    rd(A_THRESH, d); chk("R1 thresh reset", d, 0);
  endtask

  task automatic t_line0();
    logic [31:0] d;
    wr(A_PRIO + 0, 15);
    wr(A_ENABLE, 32'h1);
    irq_in[0] = 1'b1;
    settle();
    chk_out("R2 line0", 1'b0, 0);
    rd(A_ENABLE, d); chk("R2 enable bit0", d, 0);
    irq_in[0] = 1'b0;
  endtask

  task automatic t_level();
    wr(A_PRIO + 3, 5);
    irq_in[3] = 1'b1;
    settle();
    chk_out("R3 disabled", 1'b0, 0);
    wr(A_ENABLE, 32'h8);
    settle();
    chk_out("R3 R12 enabled line3", 1'b1, 3);
    irq_in[3] = 1'b0;
    settle();
    chk_out("R7 level falls", 1'b0, 0);
  endtask

  task automatic t_prio0();
    wr(A_PRIO + 4, 0);
    wr(A_ENABLE, 32'h10);
    irq_in[4] = 1'b1;
    settle();
    chk_out("R4 zero prio", 1'b0, 0);
    wr(A_PRIO + 4, 1);
    settle();
    chk_out("R4 prio one", 1'b1, 4);
    irq_in[4] = 1'b0;
    wr(A_ENABLE, 0);
  endtask

  task automatic t_winner();
    wr(A_PRIO + 3, 5);
    wr(A_PRIO + 7, 9);
    wr(A_PRIO + 20, 2);
    wr(A_ENABLE, (32'h1 << 3) | (32'h1 << 7) | (32'h1 << 20));
    irq_in[3] = 1'b1; irq_in[7] = 1'b1; irq_in[20] = 1'b1;
    settle();
    chk_out("R5 highest", 1'b1, 7);
    wr(A_PRIO + 20, 9);
    settle();
    chk_out("R6 tie 7 vs 20", 1'b1, 7);
    wr(A_PRIO + 3, 9);
    settle();
    chk_out("R6 tie 3 vs 7", 1'b1, 3);
    wr(A_PRIO + 20, 12);
    settle();
    chk_out("R5 R12 line20", 1'b1, 20);
    irq_in = '0;
    wr(A_ENABLE, 0);
    settle();
  endtask

  task automatic t_thresh();
    wr(A_PRIO + 7, 9);
    wr(A_ENABLE, 32'h80);
    irq_in[7] = 1'b1;
    wr(A_THRESH, 9);
    settle();
    chk_out("R10 thresh equal", 1'b1, 7);
    wr(A_THRESH, 10);
    chk_out("R11 old thresh still", 1'b1, 7);
    @(negedge clk);
    chk_out("R11 R10 masked next clock", 1'b0, 0);
    wr(A_PRIO + 7, 15);
    wr(A_THRESH, 16);
    settle();
    chk_out("R10 thresh 16", 1'b0, 0);
    wr(A_THRESH, 15);
    settle();
    chk_out("R10 thresh 15", 1'b1, 7);
    wr(A_THRESH, 0);
    irq_in[7] = 1'b0;
    wr(A_ENABLE, 0);
    settle();
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(A_TYPE, 32'h200);
    rd(A_TYPE, d); chk("R8 type readback", d, 32'h200);
    wr(A_PRIO + 9, 4);
    wr(A_PRIO + 3, 5);
    wr(A_ENABLE, 32'h200);
    @(negedge clk); irq_in[9] = 1'b1;
    @(negedge clk); irq_in[9] = 1'b0;
    settle();
    chk_out("R8 edge latched", 1'b1, 9);
    repeat (5) @(negedge clk);
    chk_out("R8 edge held", 1'b1, 9);
    wr(A_CLEAR, 32'h200);
    settle();
    chk_out("R9 edge cleared", 1'b0, 0);
    wr(A_ENABLE, 32'h208);
    irq_in[3] = 1'b1;
    settle();
    chk_out("R9 level line", 1'b1, 3);
    wr(A_CLEAR, 32'h8);
    settle();
    chk_out("R9 clear on level ignored", 1'b1, 3);
    irq_in[3] = 1'b0;
    settle();
  endtask

  initial begin
    irq_in = '0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_line0();
    t_level();
    t_prio0();
    t_winner();
    t_thresh();
    t_edge();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule